// File: doc/BRIEF.md
# Receive Descriptor Status Writer

This block sits behind an Ethernet receive MAC and manages a ring of receive buffer descriptors kept in a small internal memory. Each descriptor holds a 16-bit status word and a 16-bit length field. Software prepares descriptors through a host port by setting their empty bit. As frame events arrive (frame start, data bytes, buffer-full and end-of-frame strobes, and the address-match, dribble and CRC results), the block fills the current descriptor and hands it back by clearing the empty bit.

On hand-back the block sets the last-in-frame bit and the classification and error bits under fixed precedence rules. Then it moves to the next descriptor, either the following index or the programmed ring start when the wrap bit is set. If the descriptor it needs is still owned by software, the rest of the frame is dropped and an overrun pulse is raised. It also flags which incoming bytes are still within the storable limit, so that an external data mover can truncate overlong frames.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset every descriptor status and length reads 0, `overrun` is low, and the ring pointer equals `ringStart`.
- R2: A frame is accepted only if the current descriptor's status bit 15 (empty) is 1 at the `frmStart` cycle. Otherwise the whole frame is discarded, `overrun` is high for exactly the cycle after that clock edge, no descriptor changes and the pointer does not move.
- R3: On `frmEnd` (which takes precedence over `bufFull` in the same cycle) or on `bufFull`, the current descriptor is written with bit 15 = 0, readable the next cycle. Its length is `BUF_BYTES` for a buffer-full close. For an end-of-frame close it is the total frame byte count, including a byte presented in the `frmEnd` cycle.
- R4: After a close, the next descriptor is `ringStart` if the closed status had bit 13 (wrap) = 1. Otherwise it is the next index, and the last index is followed by index 0.
- R5: Write-back keeps bits 14, 13 and 12 as they were and writes bits 10, 9, 3, 1 and 0 as 0. The values of bits 14 and 12 have no effect on behaviour.
- R6: Bit 11 (last) is set only on the end-of-frame descriptor. On a buffer-full descriptor, bits 11, 8, 5, 4 and 2 are 0.
- R7: The first six bytes of a frame are the destination address. Bit 7 (broadcast) is set when all six are 0xFF. Bit 6 (multicast) is set when bit 0 of the first byte is 1 and the frame is not broadcast.
- R8: Bit 8 (miss) on the last descriptor equals `promisc` AND `addrMiss` in the `frmEnd` cycle.
- R9: Bit 5 (length violation) on the last descriptor is set when the frame byte count exceeds `maxFrameLen`. It is clear when the count is equal or lower.
- R10: On the last descriptor, if `dribble` and `crcBad` are both 1, then bit 4 = 1 and bit 2 = 0. If only `crcBad` is 1, then bit 2 = 1. If only `dribble` is 1, both bits are 0.
- R11: `dataKeep` is high in a cycle with `dataValid` of an accepted frame only while that byte is among the first 2047 of the frame. It is never high for a discarded frame or its discarded remainder.
- R12: Host reads are combinational on `hostAddr`. A host write lands next cycle, except when it targets the descriptor being written back in the same cycle; then the write-back wins.
- R13: On a buffer-full close whose next descriptor has bit 15 = 0, `overrun` pulses one cycle later. The rest of the frame up to `frmEnd` is discarded without writing any descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| promisc | input | 1 | Promiscuous mode enable |
| maxFrameLen | input | LEN_W | Maximum legal frame byte count |
| ringStart | input | IDX_W | Index used after a descriptor with wrap set |
| frmStart | input | 1 | Start of a new frame |
| dataValid | input | 1 | A frame byte is present |
| dataByte | input | 8 | Frame byte |
| bufFull | input | 1 | Current data buffer is full |
| frmEnd | input | 1 | Last byte of the frame / frame end |
| addrMiss | input | 1 | Address filter reported a miss (valid with frmEnd) |
| dribble | input | 1 | Bit count not a multiple of 8 (valid with frmEnd) |
| crcBad | input | 1 | CRC check failed (valid with frmEnd) |
| dataKeep | output | 1 | Current byte is to be stored |
| overrun | output | 1 | Frame or frame remainder was discarded |
| hostAddr | input | IDX_W | Host descriptor index |
| hostWe | input | 1 | Host write enable |
| hostWrStatus | input | 16 | Host status write data |
| hostWrLen | input | LEN_W | Host length write data |
| hostRdStatus | output | 16 | Status of descriptor at hostAddr |
| hostRdLen | output | LEN_W | Length of descriptor at hostAddr |

## Verification
Two events can fall in the same cycle. One is the end-of-frame write-back, which also counts a final byte presented alongside `frmEnd`. The other is a host write to the very descriptor being closed. The bench sends a frame with the host write aimed at that descriptor on the `frmEnd` cycle. It expects the closed status and the full byte count to survive, not the host's empty value. Separate frames present the last destination-address byte and other final bytes together with `frmEnd`, and the bench checks that they still count toward the length and the classification bits.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int B_EMPTY  = 15;
  localparam int B_SWA    = 14;
  localparam int B_WRAP   = 13;
  localparam int B_SWB    = 12;
  localparam int B_LAST   = 11;
  localparam int B_MISS   = 8;
  localparam int B_BCAST  = 7;
  localparam int B_MCAST  = 6;
  localparam int B_LONG   = 5;
  localparam int B_NONOCT = 4;
  localparam int B_CRC    = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_RECV, PH_DROP} rxdPhase_t;

  typedef struct packed {
    logic acceptFrame;
    logic countByte;
    logic closeBuf;
    logic closeLast;
    logic overrun;
  } rxdStrobes_t;
endpackage

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmStart,
  input  logic        dataValid,
  input  logic        bufFull,
  input  logic        frmEnd,
  input  logic        curEmpty,
  input  logic        nextEmpty,
  output rxdStrobes_t strb,
  output logic        overrunPulse
);
  rxdPhase_t phase, phaseNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (frmStart) begin
          if (curEmpty) begin
            strb.acceptFrame = 1'b1;
            phaseNext        = PH_RECV;
          end else begin
            strb.overrun = 1'b1;
            phaseNext    = PH_DROP;
          end
        end
      end
      PH_RECV: begin
        strb.countByte = dataValid;
        if (frmEnd) begin
          strb.closeLast = 1'b1;
          phaseNext      = PH_IDLE;
        end else if (bufFull) begin
          strb.closeBuf = 1'b1;
          if (!nextEmpty) begin
            strb.overrun = 1'b1;
            phaseNext    = PH_DROP;
          end
        end
      end
      PH_DROP: begin
        if (frmEnd) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      overrunPulse <= 1'b0;
    end else begin
      phase        <= phaseNext;
      overrunPulse <= strb.overrun;
    end
  end

  // R2 R13
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> phase == PH_DROP);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.acceptFrame, strb.closeBuf, strb.closeLast}));
endmodule

// File: rtl/rxd_datapath.sv
module rxd_datapath
  import rxd_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 256,
  parameter int KEEP_MAX  = 2047,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxdStrobes_t      strb,
  input  logic [7:0]       dataByte,
  input  logic             promisc,
  input  logic             addrMiss,
  input  logic             dribble,
  input  logic             crcBad,
  input  logic [LEN_W-1:0] maxFrameLen,
  input  logic [IDX_W-1:0] ringStart,
  input  logic [IDX_W-1:0] hostAddr,
  input  logic             hostWe,
  input  logic [15:0]      hostWrStatus,
  input  logic [LEN_W-1:0] hostWrLen,
  output logic [15:0]      hostRdStatus,
  output logic [LEN_W-1:0] hostRdLen,
  output logic             curEmpty,
  output logic             nextEmpty,
  output logic             dataKeep
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);
  localparam logic [LEN_W-1:0] BUF_LEN  = LEN_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] KEEP_LIM = LEN_W'(KEEP_MAX);

  logic [15:0]      stsMem [NUM_DESC];
  logic [LEN_W-1:0] lenMem [NUM_DESC];
  logic [IDX_W-1:0] ptrQ, nextIdx;

  logic [LEN_W-1:0] byteCnt, cntNext;
  logic [2:0]       daCnt, daCntNext;
  logic             allFF, allFFNext, groupBit, groupNext, daHit;
  logic             isBcast, isMcast;
  logic             wbEn;
  logic [15:0]      wbSts;
  logic [LEN_W-1:0] wbLen;

  // ring pointer successor
  always_comb begin
    if (stsMem[ptrQ][B_WRAP])  nextIdx = ringStart;
    else if (ptrQ == LAST_IDX) nextIdx = '0;
    else                       nextIdx = ptrQ + IDX_W'(1);
  end

  assign curEmpty  = stsMem[ptrQ][B_EMPTY];
  assign nextEmpty = stsMem[nextIdx][B_EMPTY];

  // running byte count and address classification, including this cycle's byte
  assign daHit     = strb.countByte && (daCnt < 3'd6);
  assign cntNext   = (strb.countByte && byteCnt != '1) ? byteCnt + LEN_W'(1) : byteCnt;
  assign daCntNext = daHit ? daCnt + 3'd1 : daCnt;
  assign allFFNext = daHit ? (allFF && dataByte == 8'hFF) : allFF;
  assign groupNext = (daHit && daCnt == 3'd0) ? dataByte[0] : groupBit;
  assign isBcast   = allFFNext && (daCntNext == 3'd6);
  assign isMcast   = groupNext && !isBcast;
  assign dataKeep  = strb.countByte && (byteCnt < KEEP_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= '0;
      daCnt    <= '0;
      allFF    <= 1'b1;
      groupBit <= 1'b0;
    end else if (strb.acceptFrame) begin
      byteCnt  <= '0;
      daCnt    <= '0;
      allFF    <= 1'b1;
      groupBit <= 1'b0;
    end else begin
      byteCnt  <= cntNext;
      daCnt    <= daCntNext;
      allFF    <= allFFNext;
      groupBit <= groupNext;
    end
  end

  // write-back status word
  assign wbEn = strb.closeBuf || strb.closeLast;

  always_comb begin
    wbSts          = '0;
    wbSts[B_SWA]   = stsMem[ptrQ][B_SWA];
    wbSts[B_SWB]   = stsMem[ptrQ][B_SWB];
    wbSts[B_WRAP]  = stsMem[ptrQ][B_WRAP];
    wbSts[B_BCAST] = isBcast;
    wbSts[B_MCAST] = isMcast;
    wbLen          = BUF_LEN;
    if (strb.closeLast) begin
      wbSts[B_LAST]   = 1'b1;
      wbSts[B_MISS]   = promisc && addrMiss;
      wbSts[B_LONG]   = cntNext > maxFrameLen;
      wbSts[B_NONOCT] = dribble && crcBad;
      wbSts[B_CRC]    = crcBad && !dribble;
      wbLen           = cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        stsMem[i] <= '0;
        lenMem[i] <= '0;
      end
      ptrQ <= ringStart;
    end else begin
      if (hostWe && !(wbEn && hostAddr == ptrQ)) begin
        stsMem[hostAddr] <= hostWrStatus;
        lenMem[hostAddr] <= hostWrLen;
      end
      if (wbEn) begin
        stsMem[ptrQ] <= wbSts;
        lenMem[ptrQ] <= wbLen;
        ptrQ         <= nextIdx;
      end
    end
  end

  assign hostRdStatus = stsMem[hostAddr];
  assign hostRdLen    = lenMem[hostAddr];

  // R2
  wb_only_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> stsMem[ptrQ][B_EMPTY]);

  // R3
  handback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |=> !stsMem[$past(ptrQ)][B_EMPTY]);

  // R5
  sw_bits_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |=> (stsMem[$past(ptrQ)][B_SWA] == $past(stsMem[ptrQ][B_SWA]))
          && (stsMem[$past(ptrQ)][B_SWB] == $past(stsMem[ptrQ][B_SWB])));

  // R10
  nonoct_crc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |=> !(stsMem[$past(ptrQ)][B_NONOCT] && stsMem[$past(ptrQ)][B_CRC]));
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxd_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 256,
  parameter int KEEP_MAX  = 2047,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             promisc,
  input  logic [LEN_W-1:0] maxFrameLen,
  input  logic [IDX_W-1:0] ringStart,
  input  logic             frmStart,
  input  logic             dataValid,
  input  logic [7:0]       dataByte,
  input  logic             bufFull,
  input  logic             frmEnd,
  input  logic             addrMiss,
  input  logic             dribble,
  input  logic             crcBad,
  output logic             dataKeep,
  output logic             overrun,
  input  logic [IDX_W-1:0] hostAddr,
  input  logic             hostWe,
  input  logic [15:0]      hostWrStatus,
  input  logic [LEN_W-1:0] hostWrLen,
  output logic [15:0]      hostRdStatus,
  output logic [LEN_W-1:0] hostRdLen
);
  rxdStrobes_t strb;
  logic        curEmpty, nextEmpty;

  rxd_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frmStart     (frmStart),
    .dataValid    (dataValid),
    .bufFull      (bufFull),
    .frmEnd       (frmEnd),
    .curEmpty     (curEmpty),
    .nextEmpty    (nextEmpty),
    .strb         (strb),
    .overrunPulse (overrun)
  );

  rxd_datapath #(
    .NUM_DESC  (NUM_DESC),
    .LEN_W     (LEN_W),
    .BUF_BYTES (BUF_BYTES),
    .KEEP_MAX  (KEEP_MAX)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .dataByte     (dataByte),
    .promisc      (promisc),
    .addrMiss     (addrMiss),
    .dribble      (dribble),
    .crcBad       (crcBad),
    .maxFrameLen  (maxFrameLen),
    .ringStart    (ringStart),
    .hostAddr     (hostAddr),
    .hostWe       (hostWe),
    .hostWrStatus (hostWrStatus),
    .hostWrLen    (hostWrLen),
    .hostRdStatus (hostRdStatus),
    .hostRdLen    (hostRdLen),
    .curEmpty     (curEmpty),
    .nextEmpty    (nextEmpty),
    .dataKeep     (dataKeep)
  );
endmodule

// File: tb/sim_rx_desc_writer.sv
module sim_rx_desc_writer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        promisc = 1'b0;
  logic [15:0] maxFrameLen = 16'd1518;
  logic [2:0]  ringStart = 3'd0;
  logic        frmStart = 1'b0, dataValid = 1'b0, bufFull = 1'b0, frmEnd = 1'b0;
  logic [7:0]  dataByte = 8'h00;
  logic        addrMiss = 1'b0, dribble = 1'b0, crcBad = 1'b0;
  logic        dataKeep, overrun;
  logic [2:0]  hostAddr = 3'd0;
  logic        hostWe = 1'b0;
  logic [15:0] hostWrStatus = 16'h0, hostWrLen = 16'h0;
  logic [15:0] hostRdStatus, hostRdLen;

  int checks = 0;
  int errors = 0;
  int ovSeen = 0;

  localparam logic [47:0] DA_UNI   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] DA_BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] DA_MCAST = 48'h01_00_5E_00_00_01;

  always #10 clk = ~clk;

  rx_desc_writer u0 (
    .clk(clk), .rstN(rstN), .promisc(promisc), .maxFrameLen(maxFrameLen),
    .ringStart(ringStart), .frmStart(frmStart), .dataValid(dataValid),
    .dataByte(dataByte), .bufFull(bufFull), .frmEnd(frmEnd), .addrMiss(addrMiss),
    .dribble(dribble), .crcBad(crcBad), .dataKeep(dataKeep), .overrun(overrun),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostWrStatus(hostWrStatus),
    .hostWrLen(hostWrLen), .hostRdStatus(hostRdStatus), .hostRdLen(hostRdLen)
  );

  always @(negedge clk) if (rstN && overrun) ovSeen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm(input int idx, input logic [15:0] sts);
    @(negedge clk);
    hostAddr = 3'(idx); hostWe = 1'b1; hostWrStatus = sts; hostWrLen = 16'h0;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [15:0] sts, output logic [15:0] len);
    hostAddr = 3'(idx);
    #1;
    sts = hostRdStatus;
    len = hostRdLen;
  endtask

  task automatic sendFrame(input logic [47:0] da, input int nBytes, input int bufAt,
                           input logic dri, input logic crc, input logic miss,
                           input int clashIdx, output int kept);
    kept = 0;
    @(negedge clk);
    frmStart = 1'b1;
    @(negedge clk);
    frmStart = 1'b0;
    for (int i = 0; i < nBytes; i++) begin
      dataValid = 1'b1;
      dataByte  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i);
      bufFull   = (i + 1 == bufAt);
      frmEnd    = (i == nBytes - 1);
      addrMiss  = frmEnd ? miss : 1'b0;
      dribble   = frmEnd ? dri : 1'b0;
      crcBad    = frmEnd ? crc : 1'b0;
      if (frmEnd && clashIdx >= 0) begin
        hostAddr = 3'(clashIdx); hostWe = 1'b1; hostWrStatus = 16'h8000; hostWrLen = 16'h0;
      end
      #2;
      if (dataKeep) kept++;
      @(negedge clk);
    end
    dataValid = 1'b0; bufFull = 1'b0; frmEnd = 1'b0;
    addrMiss = 1'b0; dribble = 1'b0; crcBad = 1'b0; hostWe = 1'b0;
  endtask

  task automatic expectDesc(input string req, input int idx, input logic [15:0] s, input logic [15:0] l);
    logic [15:0] rs, rl;
    rd(idx, rs, rl);
    chk({req, " status"}, {16'h0, rs}, {16'h0, s});
    chk({req, " length"}, {16'h0, rl}, {16'h0, l});
  endtask

  task automatic testReset();
    logic [15:0] s, l;
    for (int i = 0; i < 8; i++) begin
      rd(i, s, l);
      chk("R1 reset status", {16'h0, s}, 32'h0);
      chk("R1 reset length", {16'h0, l}, 32'h0);
    end
    chk("R1 overrun idle", {31'h0, overrun}, 32'h0);
  endtask

  task automatic testBasic();
    int k;
    // R5: software bits and reserved bits set on the armed descriptor
    arm(0, 16'hD608);
    sendFrame(DA_UNI, 64, 0, 1'b0, 1'b0, 1'b0, -1, k);
    expectDesc("R3 R5 R6 unicast", 0, 16'h5800, 16'd64);
    chk("R11 keep short frame", k, 64);
    arm(1, 16'h8000);
    promisc = 1'b1;
    sendFrame(DA_BCAST, 60, 0, 1'b0, 1'b0, 1'b1, -1, k);
    expectDesc("R7 R8 broadcast miss", 1, 16'h0980, 16'd60);
    arm(2, 16'h8000);
    promisc = 1'b0;
    sendFrame(DA_MCAST, 80, 0, 1'b0, 1'b0, 1'b1, -1, k);
    expectDesc("R7 R8 multicast no-promisc", 2, 16'h0840, 16'd80);
  endtask

  task automatic testErrors();
    int k;
    arm(3, 16'h8000);
    sendFrame(DA_UNI, 70, 0, 1'b0, 1'b1, 1'b0, -1, k);
    expectDesc("R10 crc only", 3, 16'h0804, 16'd70);
    arm(4, 16'h8000);
    sendFrame(DA_UNI, 70, 0, 1'b1, 1'b1, 1'b0, -1, k);
    expectDesc("R10 non-octet over crc", 4, 16'h0810, 16'd70);
    arm(5, 16'h8000);
    sendFrame(DA_UNI, 70, 0, 1'b1, 1'b0, 1'b0, -1, k);
    expectDesc("R10 dribble only", 5, 16'h0800, 16'd70);
  endtask

  task automatic testLengthWrap();
    int k;
    maxFrameLen = 16'd100;
    arm(6, 16'h8000);
    sendFrame(DA_UNI, 101, 0, 1'b0, 1'b0, 1'b0, -1, k);
    expectDesc("R9 over max", 6, 16'h0820, 16'd101);
    arm(7, 16'hA000);
    sendFrame(DA_UNI, 100, 0, 1'b0, 1'b0, 1'b0, -1, k);
    expectDesc("R9 R4 equal max wrap kept", 7, 16'h2800, 16'd100);
    maxFrameLen = 16'd1518;
  endtask

  task automatic testMultiBuf();
    int k;
    arm(0, 16'h8000);
    arm(1, 16'h8000);
    sendFrame(DA_UNI, 300, 256, 1'b0, 1'b1, 1'b0, -1, k);
    // R4: wrap on desc 7 sent the pointer back to ringStart 0
    expectDesc("R4 R6 first buffer", 0, 16'h0000, 16'd256);
    expectDesc("R3 R6 last buffer", 1, 16'h0804, 16'd300);
  endtask

  task automatic testOverrunStart();
    int k, ov0;
    ov0 = ovSeen;
    sendFrame(DA_UNI, 20, 0, 1'b0, 1'b0, 1'b0, -1, k);
    chk("R2 overrun pulse", ovSeen - ov0, 1);
    chk("R11 R2 no keep on drop", k, 0);
    expectDesc("R2 busy desc untouched", 2, 16'h0840, 16'd80);
    arm(2, 16'h8000);
    sendFrame(DA_UNI, 40, 0, 1'b0, 1'b0, 1'b0, -1, k);
    expectDesc("R2 pointer held", 2, 16'h0800, 16'd40);
  endtask

  task automatic testOverrunMid();
    int k, ov0;
    ov0 = ovSeen;
    arm(3, 16'h8000);
    sendFrame(DA_UNI, 300, 256, 1'b0, 1'b1, 1'b0, -1, k);
    chk("R13 overrun pulse", ovSeen - ov0, 1);
    chk("R13 R11 keep stops", k, 256);
    expectDesc("R13 closed buffer", 3, 16'h0000, 16'd256);
    expectDesc("R13 busy next untouched", 4, 16'h0810, 16'd70);
  endtask

  task automatic testRingStart();
    int k;
    ringStart = 3'd5;
    arm(4, 16'hA000);
    arm(5, 16'h8000);
    arm(0, 16'h8000);
    sendFrame(DA_UNI, 50, 0, 1'b0, 1'b0, 1'b0, -1, k);
    expectDesc("R4 wrap desc", 4, 16'h2800, 16'd50);
    sendFrame(DA_UNI, 50, 0, 1'b0, 1'b0, 1'b0, -1, k);
    expectDesc("R4 went to ring start", 5, 16'h0800, 16'd50);
    expectDesc("R4 index 0 untouched", 0, 16'h8000, 16'd0);
    ringStart = 3'd0;
  endtask

  task automatic testTruncate();
    int k;
    arm(6, 16'h8000);
    sendFrame(DA_UNI, 2049, 0, 1'b0, 1'b0, 1'b0, -1, k);
    chk("R11 keep limit", k, 2047);
    expectDesc("R9 R3 long frame", 6, 16'h0820, 16'd2049);
  endtask

  task automatic testClash();
    int k;
    arm(7, 16'h8000);
    sendFrame(DA_UNI, 30, 0, 1'b0, 1'b0, 1'b0, 7, k);
    expectDesc("R12 write-back wins", 7, 16'h0800, 16'd30);
    // R4: index 7 without wrap goes on to index 0; DA ends on frmEnd cycle
    sendFrame(DA_BCAST, 6, 0, 1'b0, 1'b0, 1'b0, -1, k);
    expectDesc("R4 R7 natural wrap short bcast", 0, 16'h0880, 16'd6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBasic();
    testErrors();
    testLengthWrap();
    testMultiBuf();
    testOverrunStart();
    testOverrunMid();
    testRingStart();
    testTruncate();
    testClash();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule